// File: doc/BRIEF.md
# SPI Host Controller with Word FIFOs

This block is a register-mapped SPI bus master. Software talks to it over a small 32-bit register port: it writes outgoing words into a transmit FIFO, reads incoming words from a receive FIFO, and sets the clock mode, bit order and slave selects through a control word and a select word. The shift engine drives the serial clock, the outgoing data line and active-low selects, and it samples the incoming data line. Each word shifted out returns one received word.

The word width and the serial clock divider are build-time parameters, and software cannot change them. A typical transfer runs like this. Software sets the hold bit, preloads the transmit FIFO, picks a slave and then clears the hold bit. The engine then sends the queued words with no gap between them. A one-cycle drain event tells software that the transmit FIFO has run dry and the last word has finished. Software then drains the receive FIFO until its empty flag is set.

The register port is a simple strobe interface. A write takes effect on the clock edge where `bus_wr` is high. For a read, `bus_rd` is held high for one cycle, and `bus_rdata` is valid from the following edge.

Top module: `spi_host`

## Requirements
- R1: After reset the status word reads 0x05 (receive empty and transmit empty), the control word reads 0, the select word reads all ones, every `ss_n` line is high, `sclk` is low and `tx_empty_evt` is low.
- R2: The register offsets are control 0x60, status 0x64, transmit data 0x68, receive data 0x6C and select 0x70. Control bits are: bit1 enable, bit2 master, bit3 clock polarity, bit4 clock phase, bit5 transmit FIFO flush, bit6 receive FIFO flush, bit7 manual select, bit8 hold, bit9 LSB first. Control reads back every bit except bits 5 and 6, which read as 0.
- R3: While the hold bit (bit8) is set, or while enable or master is clear, written words are queued and `sclk` does not toggle. After the hold is released, all queued words are shifted without any gap.
- R4: When idle, `sclk` sits at the polarity bit. With phase 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. All four modes carry data correctly both ways.
- R5: Bit order is MSB first when bit9 is 0 and LSB first when bit9 is 1. The setting applies to both the outgoing and the received word.
- R6: Each finished word pushes one received word into the receive FIFO. A read of 0x6C pops that word. A read of 0x6C with the FIFO empty returns 0 and leaves the status unchanged.
- R7: Status bits are: bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full, bit4 mode fault (always 0). A write to 0x68 while the transmit FIFO is full (FIFO_DEPTH words) is dropped.
- R8: Writing 1 to control bit5 or bit6 empties the transmit FIFO or the receive FIFO in one cycle.
- R9: With manual select set, `ss_n` follows the select register at all times. With manual select clear, `ss_n` is all ones while idle and equals the select register while words are shifting. Selecting slave n means clearing only bit n.
- R10: `tx_empty_evt` is a one-cycle pulse, raised once per burst, in the cycle after the final edge of a word that finishes with the transmit FIFO empty.
- R11: Every `sclk` half period lasts CLK_DIV cycles, including the step from one word to the next within a burst, so a word takes 2*WORD_W*CLK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| tx_empty_evt | output | 1 | Burst-drained pulse |

## Verification
The hardest case to reach from the ports is the hand-off between two words inside one burst. The next word has to load on the same edge that ends the previous one, and the transmit FIFO must hold data at that moment. The bench reaches this by setting the hold bit, preloading three words and up to a full FIFO of sixteen, and then releasing the hold. The bench slave timestamps every clock edge so that any widened half period is caught. The same preload also drives the transmit FIFO to full so that an extra write can be shown to be dropped, and it fills the receive FIFO until its full flag is set.

// File: rtl/spi_host_pkg.sv
// Shared constants and types for the SPI host controller.
// Assumes an 8-bit byte offset on the register port.
package spi_host_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_STAT = 8'h64;
    localparam logic [7:0] OFS_TXD  = 8'h68;
    localparam logic [7:0] OFS_RXD  = 8'h6C;
    localparam logic [7:0] OFS_SSEL = 8'h70;

    localparam int CB_EN    = 1;
    localparam int CB_MST   = 2;
    localparam int CB_CPOL  = 3;
    localparam int CB_CPHA  = 4;
    localparam int CB_TXRST = 5;
    localparam int CB_RXRST = 6;
    localparam int CB_MANSS = 7;
    localparam int CB_HOLD  = 8;
    localparam int CB_LSB   = 9;

    typedef struct packed {
        logic lsb;
        logic hold;
        logic man_ss;
        logic cpha;
        logic cpol;
        logic master;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/spi_host_fifo.sv
// Synchronous first-word-fall-through FIFO.
// Assumes DEPTH is a power of two, at least 2. A push when full and a pop when
// empty are dropped. clr empties the FIFO in one cycle.
module spi_host_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (wp == rp);
    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata   = mem[rp[AW-1:0]];

    // Storage write; no reset needed on the array.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp[AW-1:0]] <= wdata;
    end

    // Pointer update with flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/spi_host_shift.sv
// Serial shift engine: one word per load, four clock modes, optional LSB-first.
// Assumes cpol/cpha/lsb stay stable while busy. It loads the next word on the
// final edge of the current one, so the edge spacing stays even within a burst.
module spi_host_shift #(
    parameter int W       = 8,
    parameter int CLK_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_word,
    output logic         tx_pop,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         busy,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         drained
);
    localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int EW   = $clog2(2 * W);
    localparam logic [DIVW-1:0] DIV_LAST  = DIVW'(CLK_DIV - 1);
    localparam logic [EW-1:0]   EDGE_LAST = EW'(2 * W - 1);

    logic [DIVW-1:0] div_cnt;
    logic [EW-1:0]   edge_cnt;
    logic [W-1:0]    sh, rx_sh, rx_next, word_in;
    logic            sclk_r, mosi_r;
    logic            tick, last_edge, lead, samp, chg, load;

    function automatic logic [W-1:0] rev(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) rev[i] = v[W-1-i];
    endfunction

    // Edge timing and mode decode.
    always_comb begin
        tick      = busy && (div_cnt == DIV_LAST);
        last_edge = tick && (edge_cnt == EDGE_LAST);
        lead      = !edge_cnt[0];
        samp      = tick && (cpha ? !lead : lead);
        chg       = tick && (cpha ? lead : !lead);
        rx_next   = samp ? {rx_sh[W-2:0], miso} : rx_sh;
        load      = go && tx_valid && (!busy || last_edge);
        word_in   = lsb ? rev(tx_word) : tx_word;
    end

    assign tx_pop = load;
    assign sclk   = busy ? sclk_r : cpol;
    assign mosi   = mosi_r;

    // Result and drain pulses, registered once per finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_push <= 1'b0;
            drained <= 1'b0;
            rx_word <= '0;
        end else begin
            rx_push <= last_edge;
            drained <= last_edge && !load;
            if (last_edge) rx_word <= lsb ? rev(rx_next) : rx_next;
        end
    end

    // Shift state: load, edge stepping and word end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sclk_r   <= 1'b0;
            mosi_r   <= 1'b0;
            sh       <= '0;
            rx_sh    <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sclk_r   <= cpol;
            rx_sh    <= '0;
            if (!cpha) begin
                mosi_r <= word_in[W-1];
                sh     <= word_in << 1;
            end else begin
                sh     <= word_in;
            end
        end else if (last_edge) begin
            busy    <= 1'b0;
            div_cnt <= '0;
            sclk_r  <= cpol;
        end else if (tick) begin
            div_cnt  <= '0;
            edge_cnt <= edge_cnt + 1'b1;
            sclk_r   <= !sclk_r;
            rx_sh    <= rx_next;
            if (chg) begin
                mosi_r <= sh[W-1];
                sh     <= sh << 1;
            end
        end else if (busy) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_host_regs.sv
// Register file and decode for the SPI host controller.
// Assumes W <= 32 and NUM_SS <= 32. Flush bits are strobes and read as 0.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int W      = 8,
    parameter int NUM_SS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic [W-1:0]      rx_data,
    output ctrl_t             ctrl,
    output logic [NUM_SS-1:0] ss_reg,
    output logic              tx_push,
    output logic [W-1:0]      tx_wdata,
    output logic              rx_pop,
    output logic              tx_clr,
    output logic              rx_clr
);
    logic sel_ctrl, sel_stat, sel_txd, sel_rxd, sel_ssel;
    logic unused_wbits;

    assign sel_ctrl = (addr == OFS_CTRL);
    assign sel_stat = (addr == OFS_STAT);
    assign sel_txd  = (addr == OFS_TXD);
    assign sel_rxd  = (addr == OFS_RXD);
    assign sel_ssel = (addr == OFS_SSEL);

    assign tx_push  = wr && sel_txd;
    assign tx_wdata = wdata[W-1:0];
    assign rx_pop   = rd && sel_rxd;
    assign tx_clr   = wr && sel_ctrl && wdata[CB_TXRST];
    assign rx_clr   = wr && sel_ctrl && wdata[CB_RXRST];
    assign unused_wbits = ^{wdata[31:10], wdata[0]};

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr && sel_ctrl) begin
            ctrl.en     <= wdata[CB_EN];
            ctrl.master <= wdata[CB_MST];
            ctrl.cpol   <= wdata[CB_CPOL];
            ctrl.cpha   <= wdata[CB_CPHA];
            ctrl.man_ss <= wdata[CB_MANSS];
            ctrl.hold   <= wdata[CB_HOLD];
            ctrl.lsb    <= wdata[CB_LSB];
        end
    end

    // Select word storage; resets to all deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)                ss_reg <= '1;
        else if (wr && sel_ssel)   ss_reg <= wdata[NUM_SS-1:0];
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (1'b1)
                sel_ctrl: rdata <= {22'b0, ctrl.lsb, ctrl.hold, ctrl.man_ss, 2'b00,
                                    ctrl.cpha, ctrl.cpol, ctrl.master, ctrl.en, 1'b0};
                sel_stat: rdata <= {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
                sel_rxd:  rdata <= rx_empty ? 32'b0 : 32'(rx_data);
                sel_ssel: rdata <= 32'(ss_reg);
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_host.sv
// SPI host controller top: register port, two word FIFOs, shift engine.
// Assumes WORD_W is 8, 16 or 32 and FIFO_DEPTH is a power of two.
module spi_host
    import spi_host_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int CLK_DIV    = 2,
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_SS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              tx_empty_evt
);
    ctrl_t              ctrl;
    logic [NUM_SS-1:0]  ss_reg;
    logic               tx_push, rx_pop, tx_clr, rx_clr, tx_pop;
    logic [WORD_W-1:0]  tx_wdata, tx_head, rx_head, rx_word;
    logic               tx_empty, tx_full, rx_empty, rx_full;
    logic               eng_busy, rx_push, go;
    logic               cfg_cpol, cfg_hold, cfg_man;

    assign go       = ctrl.en && ctrl.master && !ctrl.hold;
    assign cfg_cpol = ctrl.cpol;
    assign cfg_hold = ctrl.hold;
    assign cfg_man  = ctrl.man_ss;
    assign ss_n     = (ctrl.man_ss || eng_busy) ? ss_reg : '1;

    spi_host_regs #(.W(WORD_W), .NUM_SS(NUM_SS)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_data(rx_head), .ctrl(ctrl), .ss_reg(ss_reg),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop),
        .tx_clr(tx_clr), .rx_clr(rx_clr)
    );

    spi_host_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spi_host_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_host_shift #(.W(WORD_W), .CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
        .lsb(ctrl.lsb), .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .miso(miso), .sclk(sclk), .mosi(mosi), .busy(eng_busy),
        .rx_push(rx_push), .rx_word(rx_word), .drained(tx_empty_evt)
    );
endmodule

// File: rtl/spi_host_chk.sv
// Protocol checker for spi_host, attached by bind.
module spi_host_chk #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sclk,
    input logic              cpol,
    input logic              hold,
    input logic              man_ss,
    input logic [NUM_SS-1:0] ss_n,
    input logic              evt,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              tx_pop,
    input logic              tx_clr
);
    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !busy |=> !busy);
    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol);
    // R9
    auto_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !man_ss && !busy |-> ss_n == '1);
    // R10
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    // R10
    evt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> !busy);
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && !tx_pop && !tx_clr |=> tx_full);
    // R8
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> tx_empty);
endmodule

bind spi_host spi_host_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .sclk(sclk), .cpol(cfg_cpol),
    .hold(cfg_hold), .man_ss(cfg_man), .ss_n(ss_n), .evt(tx_empty_evt),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_pop(tx_pop), .tx_clr(tx_clr)
);

// File: tb/tb_spi_host.sv
module tb_spi_host;
    localparam int W = 8;
    localparam int CLK_DIV = 2;
    localparam int NSS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = 32'h0, bus_rdata;
    logic sclk, mosi, miso = 1'b0, tx_empty_evt;
    logic [NSS-1:0] ss_n;

    spi_host #(.WORD_W(W), .CLK_DIV(CLK_DIV), .FIFO_DEPTH(16), .NUM_SS(NSS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n), .tx_empty_evt(tx_empty_evt)
    );

    always #4 clk = !clk;

    int checks = 0, fails = 0;
    int cyc = 0, evt_cnt = 0;
    always @(negedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (tx_empty_evt) evt_cnt <= evt_cnt + 1;

    // Scoreboard storage, written by the driver only.
    logic [W-1:0] tx_exp [256];
    logic [W-1:0] miso_w [256];
    int n_sent = 0, n_rxread = 0, arm_id = 0;
    logic cpol_b = 0, cpha_b = 0, lsb_b = 0, slave_on = 0;

    // Slave model state, owned by the slave process.
    int s_checks = 0, s_fails = 0, n_slave = 0, s_idx = 0, se = 0;
    int edges = 0, bad_gap = 0, prev_cyc = 0, arm_seen = 0;
    logic have_prev = 0, s_loaded = 0, s_last = 0, lead;
    logic [W-1:0] cur, acc, got;

    function automatic logic wbit(input logic [W-1:0] w, input int k);
        return lsb_b ? w[k] : w[W-1-k];
    endfunction

    task automatic slave_take();
        s_idx = n_slave;
        n_slave++;
        cur = miso_w[s_idx];
        s_loaded = 1;
        if (!cpha_b) miso = wbit(cur, 0);
    endtask

    // Slave and monitor: drives MISO, captures MOSI, times every clock edge.
    always @(sclk or negedge clk) begin
        if (sclk !== s_last) begin
            s_last = sclk;
            if (slave_on) begin
                edges++;
                if (have_prev && (cyc - prev_cyc) != CLK_DIV) bad_gap++;
                prev_cyc = cyc;
                have_prev = 1;
                if (s_loaded) begin
                    lead = (sclk !== cpol_b);
                    if (cpha_b && lead) miso = wbit(cur, se / 2);
                    if (cpha_b != lead) acc = {acc[W-2:0], mosi};
                    if (!cpha_b && !lead && (se / 2) < W - 1) miso = wbit(cur, se / 2 + 1);
                    se++;
                    if (se == 2 * W) begin
                        for (int i = 0; i < W; i++) got[i] = lsb_b ? acc[W-1-i] : acc[i];
                        s_checks++;
                        if (got !== tx_exp[s_idx]) begin
                            s_fails++;
                            $display("FAIL R4/R5 mosi word %0d act %h exp %h", s_idx, got, tx_exp[s_idx]);
                        end
                        se = 0;
                        s_loaded = 0;
                        if (n_slave < n_sent) slave_take();
                    end
                end
            end
        end else begin
            if (arm_id != arm_seen) begin
                arm_seen = arm_id;
                edges = 0; bad_gap = 0; have_prev = 0; se = 0;
            end
            if (!s_loaded && n_slave < n_sent) slave_take();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cw(input logic pol, input logic pha, input logic l,
                                       input logic h, input logic m);
        return 32'h6 | (32'(pol) << 3) | (32'(pha) << 4) | (32'(m) << 7) |
               (32'(h) << 8) | (32'(l) << 9);
    endfunction

    task automatic set_mode(input logic pol, input logic pha, input logic l,
                            input logic h, input logic m);
        slave_on = 0;
        cpol_b = pol; cpha_b = pha; lsb_b = l;
        bus_write(8'h60, cw(pol, pha, l, h, m));
        slave_on = 1;
        arm_id++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] t, input logic [W-1:0] m);
        tx_exp[n_sent] = t;
        miso_w[n_sent] = m;
        n_sent++;
        bus_write(8'h68, 32'(t));
    endtask

    task automatic read_rx(input string req);
        logic [31:0] d;
        bus_read(8'h6C, d);
        chk(req, d, 32'(miso_w[n_rxread]));
        n_rxread++;
    endtask

    task automatic wait_evt(input int target);
        while (evt_cnt < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired act running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 checks + s_checks + 1, fails + s_fails + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int e0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h64, d);  chk("R1 status", d, 32'h05);
        bus_read(8'h60, d);  chk("R1 control", d, 32'h0);
        bus_read(8'h70, d);  chk("R1 select word", d, 32'hF);
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 sclk", 32'(sclk), 32'h0);
        chk("R1 evt", 32'(tx_empty_evt), 32'h0);

        // R2 control readback with flush bits reading zero; R4 idle level
        bus_write(8'h60, 32'h3FE);
        bus_read(8'h60, d);  chk("R2 control readback", d, 32'h39E);
        chk("R4 idle sclk at polarity 1", 32'(sclk), 32'h1);
        bus_write(8'h60, 32'h0);
        bus_write(8'h70, 32'hE);
        bus_read(8'h70, d);  chk("R2 select readback", d, 32'hE);

        // R4 all four modes, one word each
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0], 0, 0, 0);
            e0 = evt_cnt;
            send(8'hA5 ^ 8'(m * 17), 8'h3C + 8'(m * 9));
            wait_evt(e0 + 1);
            read_rx("R4 mode rx word");
            chk("R4 idle level after word", 32'(sclk), 32'(m[1]));
            chk("R11 edge count one word", 32'(edges), 32'(2 * W));
        end

        // R5 LSB first, phase 0 and phase 1
        for (int p = 0; p < 2; p++) begin
            set_mode(0, p[0], 1, 0, 0);
            e0 = evt_cnt;
            send(8'h01, 8'h80);
            send(8'hC4, 8'h1D);
            wait_evt(e0 + 1);
            read_rx("R5 lsb rx word 0");
            read_rx("R5 lsb rx word 1");
        end

        // R3 hold preload, then back-to-back release; R9 auto select; R10; R11
        set_mode(0, 0, 0, 1, 0);
        e0 = evt_cnt;
        send(8'h5A, 8'h96);
        send(8'hF0, 8'h0F);
        send(8'h33, 8'hCC);
        repeat (60) @(negedge clk);
        chk("R3 no edges while held", 32'(edges), 32'h0);
        bus_read(8'h64, d);  chk("R3 status while held", d, 32'h01);
        chk("R9 auto idle deselect", 32'(ss_n), 32'hF);
        bus_write(8'h60, cw(0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        chk("R9 auto select during shift", 32'(ss_n), 32'hE);
        wait_evt(e0 + 1);
        chk("R10 one drain pulse per burst", 32'(evt_cnt), 32'(e0 + 1));
        chk("R11 burst edge count", 32'(edges), 32'(6 * W));
        chk("R11 even edge spacing", 32'(bad_gap), 32'h0);
        chk("R9 auto deselect after burst", 32'(ss_n), 32'hF);
        for (int i = 0; i < 3; i++) read_rx("R6 burst rx word");

        // R9 manual select follows register
        bus_write(8'h60, cw(0, 0, 0, 0, 1));
        bus_write(8'h70, 32'hB);
        chk("R9 manual select", 32'(ss_n), 32'hB);
        bus_write(8'h70, 32'hF);
        chk("R9 manual deselect", 32'(ss_n), 32'hF);
        bus_write(8'h70, 32'hE);

        // R7 full transmit FIFO drops extra write; receive FIFO fills
        set_mode(1, 1, 0, 1, 0);
        e0 = evt_cnt;
        for (int i = 0; i < 16; i++) send(8'(i * 13 + 7), 8'(i * 29 + 3));
        bus_write(8'h68, 32'hEE);
        bus_read(8'h64, d);  chk("R7 status tx full", d, 32'h09);
        bus_write(8'h60, cw(1, 1, 0, 0, 0));
        wait_evt(e0 + 1);
        chk("R7 extra word not sent", 32'(edges), 32'(16 * 2 * W));
        chk("R11 long burst spacing", 32'(bad_gap), 32'h0);
        bus_read(8'h64, d);  chk("R7 status rx full", d, 32'h06);
        for (int i = 0; i < 16; i++) read_rx("R6 full fifo rx word");

        // R6 empty read returns zero, no state change
        bus_read(8'h6C, d);  chk("R6 empty read value", d, 32'h0);
        bus_read(8'h64, d);  chk("R6 status after empty read", d, 32'h05);

        // R8 transmit flush
        set_mode(0, 0, 0, 1, 0);
        bus_write(8'h68, 32'h11);
        bus_write(8'h68, 32'h22);
        bus_write(8'h60, cw(0, 0, 0, 1, 0) | 32'h20);
        bus_read(8'h64, d);  chk("R8 tx flushed", d, 32'h05);
        bus_read(8'h60, d);  chk("R2 flush bit reads zero", d, cw(0, 0, 0, 1, 0));
        bus_write(8'h60, cw(0, 0, 0, 0, 0));
        repeat (50) @(negedge clk);
        chk("R8 no shifting after flush", 32'(edges), 32'h0);

        // R8 receive flush
        e0 = evt_cnt;
        send(8'h44, 8'h55);
        send(8'h66, 8'h77);
        wait_evt(e0 + 1);
        bus_read(8'h64, d);  chk("R6 two words received", d, 32'h04);
        bus_write(8'h60, cw(0, 0, 0, 0, 0) | 32'h40);
        bus_read(8'h64, d);  chk("R8 rx flushed", d, 32'h05);
        n_rxread += 2;
        bus_read(8'h6C, d);  chk("R8 rx read after flush", d, 32'h0);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 checks + s_checks, fails + s_fails);
        $finish;
    end
endmodule